// File: doc/BRIEF.md
# Tape Pulse Interval Classifier

This block watches a tape-write input and times the gap between successive rising edges. The input is first brought into the clock domain and passed through a level filter, so that short glitches do not count as edges. A prescaler divides the system clock by 64 and drives an interval counter. Each accepted rising edge captures the counter, restarts it, and turns the captured interval into one output byte.

In classified mode the byte is one of four ASCII letters, chosen by two programmable thresholds:
- 'A' means pause.
- 'B' means short.
- 'C' means medium.
- 'D' means long.

If the counter reaches the programmed timeout, it drops to zero and stays there. A pause therefore always reads as interval zero. Setting the short threshold to zero selects raw mode. In raw mode the low byte of the interval is sent unchanged, and the timeout is fixed at the counter's all-ones value.

Bytes leave through a valid/ready port meant for a serial transmitter. A mode state machine has three states:
- `ST_OFF`: the block is disabled.
- `ST_ARM`: enabled, waiting for the first edge, which only starts timing.
- `ST_MEAS`: each edge emits a byte.

The state transitions are:
- `ST_OFF` to `ST_ARM` when `enable` rises.
- `ST_ARM` to `ST_MEAS` on the first accepted edge.
- Any state back to `ST_OFF` when `enable` is low.

Top module: `tape_interval_classifier`

## Requirements
- R1: `tape_in` passes a two-stage synchronizer. A level change is accepted only after 4 consecutive synchronized samples differ from the current filtered level, so a pulse of 3 clocks or less produces no edge.
- R2: The interval counter advances once every 64 clocks and is cleared on each accepted rising edge. Two rising edges spaced P clocks apart capture floor((P-1)/64).
- R3: When an increment would make the counter equal to the timeout value, the counter becomes 0 and stays frozen until the next accepted edge. A later capture then reads 0.
- R4: With `thr_short` nonzero, a captured value is encoded as follows: 0 gives 0x41 ('A'); a value below `thr_short` gives 0x42 ('B'); a value below `thr_long` gives 0x43 ('C'); any other value gives 0x44 ('D').
- R5: With `thr_short` equal to 0 (raw mode), the output byte is the low 8 bits of the captured value, and the timeout is fixed at 255. An interval of 254 ticks reads 254, and one of 255 ticks reads 0.
- R6: While `enable` is low, the block is in `ST_OFF`: no byte is produced and `out_valid` and `overrun` are 0. After `enable` rises, the first accepted edge produces no byte and only starts timing.
- R7: A produced byte raises `out_valid`. `out_valid` and `out_data` hold steady until a cycle with `out_ready` high consumes the byte.
- R8: A byte produced while `out_valid` is high and `out_ready` is low is dropped, and `overrun` is set. `overrun` stays set until the block returns to `ST_OFF`.
- R9: After reset, `out_valid`, `overrun` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Mode enable; low holds the block in `ST_OFF` |
| tape_in | input | 1 | Asynchronous tape-write level |
| thr_short | input | 8 | Short/medium boundary; 0 selects raw mode |
| thr_long | input | 8 | Medium/long boundary |
| timeout | input | 8 | Counter limit in classified mode |
| out_data | output | 8 | Symbol or raw interval byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
The embedded properties assume that `thr_short`, `thr_long` and `timeout` are held constant while `enable` is high. The bound check on the counter and the symbol-range check both depend on this. The stimulus changes these settings only while `enable` is low. Tape edges are driven at exact clock multiples, with each level held for at least 16 clocks, and intervals chosen as 64n+32 so that every capture lands in the middle of a tick. The only deliberately short pulses are 3-clock glitches, used to exercise the filter.

// File: rtl/tic_pkg.sv
package tic_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } mode_e;

    localparam logic [7:0] SYM_PAUSE  = 8'h41;
    localparam logic [7:0] SYM_SHORT  = 8'h42;
    localparam logic [7:0] SYM_MEDIUM = 8'h43;
    localparam logic [7:0] SYM_LONG   = 8'h44;
endpackage

// File: rtl/tic_edge_filter.sv
module tic_edge_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [1:0]    sync_q;
    logic          sync_s;
    logic          level_q;
    logic [CW-1:0] run_q;

    assign sync_s = sync_q[1];

    // two-stage synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], din};
    end

    // level filter: accept a change after FILT_LEN differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
            rise    <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (sync_s == level_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                level_q <= sync_s;
                run_q   <= '0;
                rise    <= sync_s;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1: the filtered level only moves toward the synchronized sample
    a_r1_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(sync_s) == level_q));

    // R1: a rise marker always coincides with a filtered high level
    a_r1_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> level_q);
endmodule

// File: rtl/tic_interval_timer.sv
module tic_interval_timer #(
    parameter int DIV = 64,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         stopped
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] presc_q;
    logic [W:0]    next_w;
    logic          hit;

    assign next_w = {1'b0, count} + 1'b1;
    assign hit    = (next_w == {1'b0, limit}) || next_w[W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            count   <= '0;
            stopped <= 1'b0;
        end else if (!run || clear) begin
            presc_q <= '0;
            count   <= '0;
            stopped <= 1'b0;
        end else if (!stopped) begin
            if (presc_q == PW'(DIV - 1)) begin
                presc_q <= '0;
                if (hit) begin
                    count   <= '0;
                    stopped <= 1'b1;
                end else begin
                    count <= next_w[W-1:0];
                end
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    // R3: a timed-out counter is frozen at zero
    a_r3_frozen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (count == '0));

    // R3: the counter never reaches a nonzero limit
    a_r3_below_limit: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (limit != '0) |-> (count < limit));

    // R2: the counter only steps by one or returns to zero
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));
endmodule

// File: rtl/tape_interval_classifier.sv
module tape_interval_classifier
    import tic_pkg::*;
#(
    parameter int DIV      = 64,
    parameter int FILT_LEN = 4,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tape_in,
    input  logic [W-1:0] thr_short,
    input  logic [W-1:0] thr_long,
    input  logic [W-1:0] timeout,
    output logic [7:0]   out_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic         overrun
);
    localparam logic [W-1:0] RAW_LIMIT = '1;

    mode_e        state_q, state_d;
    logic         rise;
    logic         raw_mode;
    logic [W-1:0] limit;
    logic [W-1:0] count;
    logic         stopped;
    logic         run;
    logic         emit;
    logic [7:0]   symbol;

    assign raw_mode = (thr_short == '0);
    assign limit    = raw_mode ? RAW_LIMIT : timeout;
    assign run      = (state_q != ST_OFF);
    assign emit     = (state_q == ST_MEAS) && rise;

    tic_edge_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tape_in),
        .rise  (rise)
    );

    tic_interval_timer #(.DIV(DIV), .W(W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clear   (rise),
        .limit   (limit),
        .count   (count),
        .stopped (stopped)
    );

    // symbol encoder
    always_comb begin
        if (raw_mode)               symbol = count[7:0];
        else if (count == '0)       symbol = SYM_PAUSE;
        else if (count < thr_short) symbol = SYM_SHORT;
        else if (count < thr_long)  symbol = SYM_MEDIUM;
        else                        symbol = SYM_LONG;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_d = ST_ARM;
            ST_ARM:  if (!enable) state_d = ST_OFF;
                     else if (rise) state_d = ST_MEAS;
            ST_MEAS: if (!enable) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output register and overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            overrun   <= 1'b0;
        end else if (state_q == ST_OFF) begin
            out_valid <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (emit) begin
                if (out_valid && !out_ready) begin
                    overrun <= 1'b1;
                end else begin
                    out_valid <= 1'b1;
                    out_data  <= symbol;
                end
            end
        end
    end

    // R7: an unaccepted byte is held unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (out_valid && !out_ready && state_q != ST_OFF) |=> (out_valid && $stable(out_data)));

    // R6: bytes only appear from the measuring state
    a_r6_only_measuring: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(state_q) == ST_MEAS));

    // R4: classified output is one of the four letters
    a_r4_symbol_range: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (out_valid && !raw_mode) |-> (out_data >= SYM_PAUSE && out_data <= SYM_LONG));

    // R8: overrun is sticky while enabled
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && state_q != ST_OFF && enable) |=> overrun);

    // R6: disabled block shows no output activity
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_OFF) |-> (!out_valid && !overrun));
endmodule

// File: tb/sim_tape_interval_classifier.sv
`timescale 1ns/1ps
module sim_tape_interval_classifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tape_in = 1'b0;
    logic [7:0] thr_short = 8'd0;
    logic [7:0] thr_long = 8'd0;
    logic [7:0] timeout = 8'd0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       overrun;

    int checks = 0;
    int failures = 0;
    int seq [0:31];
    int seq_len = 0;
    logic [7:0] got [0:63];
    int ngot = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tape_interval_classifier u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tape_in(tape_in),
        .thr_short(thr_short), .thr_long(thr_long), .timeout(timeout),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .overrun(overrun)
    );

    // consumer monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && ngot < 64) begin
            got[ngot] = out_data;
            ngot = ngot + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [7:0] exp_sym(input int n, input int t0, input int t1, input int tmo);
        int lim;
        int c;
        lim = (t0 == 0) ? 255 : ((tmo == 0) ? 256 : tmo);
        c = (n >= lim) ? 0 : n;
        if (t0 == 0) return 8'(c);
        if (c == 0) return 8'h41;
        if (c < t0) return 8'h42;
        if (c < t1) return 8'h43;
        return 8'h44;
    endfunction

    // one rising edge, then a low phase; rise-to-rise spacing 64n+32
    task automatic pulse(input int n, input bit glitch);
        tape_in = 1'b1;
        tick(16);
        tape_in = 1'b0;
        if (glitch && n >= 1) begin
            tick(20);
            tape_in = 1'b1;
            tick(3);
            tape_in = 1'b0;
            tick(64 * n + 16 - 23);
        end else begin
            tick(64 * n + 16);
        end
    endtask

    task automatic start(input int t0, input int t1, input int tmo);
        enable = 1'b0;
        tick(5);
        thr_short = 8'(t0);
        thr_long = 8'(t1);
        timeout = 8'(tmo);
        enable = 1'b1;
        tick(3);
        ngot = 0;
    endtask

    task automatic run_seq(input int t0, input int t1, input int tmo, input bit glitch, input string req);
        start(t0, t1, tmo);
        for (int i = 0; i < seq_len; i++) pulse(seq[i], glitch);
        tape_in = 1'b1;
        tick(16);
        tape_in = 1'b0;
        tick(30);
        chk(ngot == seq_len, {req, " R6 byte count"}, ngot, seq_len);
        for (int i = 0; i < seq_len && i < ngot; i++)
            chk(got[i] == exp_sym(seq[i], t0, t1, tmo), req, got[i], exp_sym(seq[i], t0, t1, tmo));
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd1234);
        tick(3);
        // R9: reset state
        chk(out_valid == 1'b0, "R9 valid", out_valid, 0);
        chk(overrun == 1'b0, "R9 overrun", overrun, 0);
        chk(out_data == 8'h00, "R9 data", out_data, 0);
        rst_n = 1'b1;
        tick(3);

        // R6: disabled, edges produce nothing
        ngot = 0;
        pulse(2, 1'b0);
        pulse(2, 1'b0);
        tick(20);
        chk(ngot == 0, "R6 disabled output", ngot, 0);
        chk(out_valid == 1'b0, "R6 disabled valid", out_valid, 0);

        // R4 R3 R2: directed classification, including timeout values
        seq_len = 10;
        seq[0] = 0; seq[1] = 1; seq[2] = 2; seq[3] = 3; seq[4] = 5;
        seq[5] = 6; seq[6] = 8; seq[7] = 9; seq[8] = 12; seq[9] = 4;
        run_seq(3, 6, 9, 1'b0, "R4 R3 directed");

        // R1: 3-clock glitches in every low phase leave the result intact
        run_seq(3, 6, 9, 1'b1, "R1 glitch");

        // R5: raw mode, including the fixed 255 limit
        seq_len = 5;
        seq[0] = 0; seq[1] = 7; seq[2] = 17; seq[3] = 254; seq[4] = 255;
        run_seq(0, 9, 3, 1'b0, "R5 raw");

        // R2 R4: random sessions
        for (int s = 0; s < 2; s++) begin
            int t0;
            int t1;
            int tmo;
            t0 = 1 + int'($urandom % 10);
            t1 = t0 + int'($urandom % 4);
            tmo = 3 + int'($urandom % 12);
            seq_len = 16;
            for (int i = 0; i < 16; i++) seq[i] = int'($urandom % 15);
            run_seq(t0, t1, tmo, 1'b0, "R2 R4 random");
        end

        // R7 R8: consumer stalls
        out_ready = 1'b0;
        seq_len = 3;
        seq[0] = 1; seq[1] = 4; seq[2] = 7;
        start(3, 6, 9);
        for (int i = 0; i < seq_len; i++) pulse(seq[i], 1'b0);
        tape_in = 1'b1;
        tick(16);
        tape_in = 1'b0;
        tick(30);
        chk(out_valid == 1'b1, "R7 held valid", out_valid, 1);
        chk(out_data == 8'h42, "R7 held data", out_data, 8'h42);
        chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
        out_ready = 1'b1;
        tick(3);
        chk(ngot == 1, "R8 dropped bytes", ngot, 1);
        chk(out_valid == 1'b0, "R7 consumed", out_valid, 0);
        chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
        enable = 1'b0;
        tick(4);
        chk(overrun == 1'b0, "R8 R6 cleared when off", overrun, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule